// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block models the control logic of a byte-wide parallel nonvolatile memory. Three active-low strobes (chip enable, write enable, output enable) are decoded into read, write, standby and idle modes. The host loads bytes one strobe at a time. Every accepted byte goes into a 32-entry page buffer, and each one restarts a load-window timer. When the window expires with no further byte, a self-timed program cycle copies every buffered byte into the array at once. The buffer then empties itself.

While the program cycle runs, a read does not return array data. It returns a status byte. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips on each read. The host polls either bit to find the end of the cycle. A supply-low input blocks writes. Both timers count clock cycles, so the default of 625,000 cycles is 5 ms at 125 MHz. The array is a plain register array of 8192 bytes.

Top module: `eep_page_ctrl`

## Requirements
- R1: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1 (read). With `ce_n`=1 (standby), or with `oe_n`=1 and `we_n`=1, `dout_en` is 0 and `dout` is all zero.
- R2: A write is taken when the combined strobe is released. The combined strobe is active when `ce_n`=0, `we_n`=0 and `oe_n`=1. Release means either `we_n` or `ce_n` rising ends that condition. The address and data sampled in the last active cycle are the ones used. `addr[COL_W-1:0]` is the byte in the page and `addr[ADDR_W-1:COL_W]` is the page.
- R3: Programming starts exactly LOAD_CYC cycles after the last accepted byte. Every accepted byte restarts this window, so bytes spaced closer than LOAD_CYC all join one program cycle.
- R4: The program cycle lasts PROG_CYC cycles. At its end, all buffered bytes are written to the array in a single cycle, and reads return the new data.
- R5: A byte of the page that was not loaded in the window keeps its previous array value.
- R6: A read during the program cycle returns a status byte. Its top bit is the complement of the top bit of the last accepted byte. The bits below bit DATA_W-2 read as 0.
- R7: Bit DATA_W-2 of the status byte is 0 on the first read after programming starts, and it inverts after each completed read.
- R8: A write strobe released during a program cycle is ignored. It changes no array byte and starts no load window.
- R9: While `vcc_low`=1, released write strobes are ignored.
- R10: The first byte loaded into an empty buffer fixes the page. A later byte in the same window that carries another page address is stored at its column within the first page.
- R11: The page buffer is empty when a program cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, column in the low COL_W bits |
| din | input | DATA_W | Write data |
| vcc_low | input | 1 | Supply-low indication; blocks writes |
| dout | output | DATA_W | Read data or busy status |
| dout_en | output | 1 | High while the block drives `dout` |

## Verification
The assertions assume the strobes and address are synchronous to `clk` and are stable at the edges where they are sampled. They also assume that a write holds its address and data until the cycle in which the strobe is released. The stimulus drives every input on the falling clock edge and keeps each strobe low for a whole cycle before releasing it. It spaces bytes meant for one page closer together than the load window. Before checking data, it waits longer than the load window plus the program time, so each sweep sees a settled array.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    MD_STANDBY = 2'd0,
    MD_READ    = 2'd1,
    MD_WRITE   = 2'd2,
    MD_IDLE    = 2'd3
  } eep_mode_e;
endpackage

// File: rtl/eep_mode_dec.sv
module eep_mode_dec
  import eep_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  output eep_mode_e mode,
  output logic      rd,
  output logic      wr_act
);
  always_comb begin
    if (ce_n)                  mode = MD_STANDBY;
    else if (!oe_n && we_n)    mode = MD_READ;
    else if (oe_n && !we_n)    mode = MD_WRITE;
    else                       mode = MD_IDLE;
  end

  assign rd     = (mode == MD_READ);
  assign wr_act = (mode == MD_WRITE);
endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int LOAD_CYC = 12500,
  parameter int PROG_CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_act,
  input  logic vcc_low,
  output logic accept,
  output logic busy,
  output logic commit
);
  localparam int LCNT_W = $clog2(LOAD_CYC + 1);
  localparam int PCNT_W = $clog2(PROG_CYC + 1);

  logic              wr_q, loading_q, loading_d, busy_q, busy_d;
  logic [LCNT_W-1:0] lcnt_q, lcnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;

  assign accept = wr_q && !wr_act && !busy_q && !vcc_low;
  assign busy   = busy_q;

  always_comb begin
    loading_d = loading_q;
    lcnt_d    = lcnt_q;
    busy_d    = busy_q;
    pcnt_d    = pcnt_q;
    commit    = 1'b0;
    if (busy_q) begin
      if (pcnt_q == '0) begin
        busy_d = 1'b0;
        commit = 1'b1;
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end else if (accept) begin
      loading_d = 1'b1;
      lcnt_d    = LCNT_W'(LOAD_CYC - 1);
    end else if (loading_q) begin
      if (lcnt_q == '0) begin
        loading_d = 1'b0;
        busy_d    = 1'b1;
        pcnt_d    = PCNT_W'(PROG_CYC - 1);
      end else begin
        lcnt_d = lcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      loading_q <= 1'b0;
      lcnt_q    <= '0;
      busy_q    <= 1'b0;
      pcnt_q    <= '0;
    end else begin
      wr_q      <= wr_act;
      loading_q <= loading_d;
      lcnt_q    <= lcnt_d;
      busy_q    <= busy_d;
      pcnt_q    <= pcnt_d;
    end
  end

  // R3
  prog_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(loading_q && lcnt_q == '0 && !accept));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8,
  localparam int COLS  = 1 << COL_W,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       commit,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          din,
  output logic [ROW_W-1:0]           tag,
  output logic [COLS-1:0]            valid,
  output logic [COLS-1:0][DATA_W-1:0] bdata,
  output logic                       last_msb
);
  logic [ROW_W-1:0]           tag_q, tag_d;
  logic [COLS-1:0]            valid_q, valid_d;
  logic [COLS-1:0][DATA_W-1:0] bdata_q;
  logic                       msb_q;
  logic [COL_W-1:0]           col;

  assign col = addr[COL_W-1:0];

  always_comb begin
    tag_d   = tag_q;
    valid_d = valid_q;
    if (commit) begin
      valid_d = '0;
    end else if (accept) begin
      if (valid_q == '0) tag_d = addr[ADDR_W-1:COL_W];
      valid_d[col] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      valid_q <= '0;
      msb_q   <= 1'b0;
    end else begin
      tag_q   <= tag_d;
      valid_q <= valid_d;
      if (accept) msb_q <= din[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (accept) bdata_q[col] <= din;
  end

  assign tag      = tag_q;
  assign valid    = valid_q;
  assign bdata    = bdata_q;
  assign last_msb = msb_q;

  // R10
  page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid_q) != '0 && valid_q != '0) |-> $stable(tag_q));
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int COL_W    = 5,
  parameter int DATA_W   = 8,
  parameter int LOAD_CYC = 12500,
  parameter int PROG_CYC = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              vcc_low,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int COLS  = 1 << COL_W;
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int ROWS  = 1 << ROW_W;

  logic [1:0]                  rst_sync_q;
  logic                        rst_int_n;
  eep_mode_e                   mode;
  logic                        rd, wr_act, accept, busy, commit, last_msb;
  logic                        rd_q, tgl_q, tgl_d;
  logic [ROW_W-1:0]            tag;
  logic [COLS-1:0]             valid;
  logic [COLS-1:0][DATA_W-1:0] bdata;
  logic [DATA_W-1:0]           mem_q [ROWS][COLS];
  logic [DATA_W-1:0]           status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eep_mode_dec u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .mode(mode), .rd(rd), .wr_act(wr_act)
  );

  eep_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .wr_act(wr_act), .vcc_low(vcc_low),
    .accept(accept), .busy(busy), .commit(commit)
  );

  eep_page_buf #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .commit(commit),
    .addr(addr), .din(din), .tag(tag), .valid(valid), .bdata(bdata),
    .last_msb(last_msb)
  );

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int c = 0; c < COLS; c++) begin
        if (valid[c]) mem_q[tag][c] <= bdata[c];
      end
    end
  end

  always_comb begin
    tgl_d = tgl_q;
    if (!busy)            tgl_d = 1'b0;
    else if (rd_q && !rd) tgl_d = !tgl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      rd_q  <= rd;
      tgl_q <= tgl_d;
    end
  end

  always_comb begin
    status             = '0;
    status[DATA_W-1]   = !last_msb;
    status[DATA_W-2]   = tgl_q;
  end

  assign dout_en = rd;
  assign dout    = !rd  ? '0 :
                   busy ? status : mem_q[addr[ADDR_W-1:COL_W]][addr[COL_W-1:0]];

  // R1
  drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dout_en |-> (!ce_n && !oe_n && we_n));
  // R7
  poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && rd_q && !rd) |=> (tgl_q != $past(tgl_q)));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> ($stable(valid) || valid == '0));
  // R9
  supply_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vcc_low && !busy) |=> $stable(valid));
  // R11
  buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (valid == '0));
endmodule

// File: tb/eep_page_ctrl_bench.sv
module eep_page_ctrl_bench;
  localparam int AW = 7;
  localparam int CW = 5;
  localparam int DW = 8;
  localparam int LC = 16;
  localparam int PC = 40;
  localparam int SETTLE = LC + PC + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vcc_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  eep_page_ctrl #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW),
                  .LOAD_CYC(LC), .PROG_CYC(PC)) u_eep_page_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vcc_low(vcc_low), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit ce_ctl);
    @(negedge clk);
    addr = AW'(a); din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input int a, input string req, input logic [7:0] exp);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #2;
    check(req, {dout_en, dout}, {1'b1, exp});
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    // R1: idle inputs during reset
    check("R1 reset", {dout_en, dout}, 9'h000);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2 R4: sweep every page, WE-controlled on even pages, CE-controlled on odd
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 32; c++) wr(p * 32 + c, pat(p * 32 + c), p[0]);
      wait_cyc(SETTLE);
    end
    for (int a = 0; a < 128; a++) rd(a, "R2 R4 sweep", pat(a));

    // R1: standby and output-disabled
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #2;
    check("R1 standby", {dout_en, dout}, 9'h000);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #2;
    check("R1 oe high", {dout_en, dout}, 9'h000);
    @(negedge clk); ce_n = 1'b1;

    // R6 R7 R8: busy status, toggle, ignored write
    wr(35, 8'h5A, 1'b0);
    wait_cyc(LC + 4);
    rd(35, "R6 status", 8'h80);
    rd(35, "R7 toggle", 8'hC0);
    rd(0, "R7 toggle back", 8'h80);
    wr(71, 8'hEE, 1'b0);
    wait_cyc(SETTLE + LC + PC);
    rd(35, "R4 new byte", 8'h5A);
    rd(36, "R5 untouched", pat(36));
    rd(71, "R8 ignored", pat(71));

    // R9: supply low
    vcc_low = 1'b1;
    wr(1, 8'h33, 1'b1);
    vcc_low = 1'b0;
    wait_cyc(SETTLE);
    rd(1, "R9 inhibit", pat(1));

    // R10: page lock
    wr(4, 8'h44, 1'b0);
    wr(101, 8'h55, 1'b0);
    wait_cyc(SETTLE);
    rd(4, "R10 first", 8'h44);
    rd(5, "R10 locked", 8'h55);
    rd(101, "R10 other page", pat(101));

    // R3: window restart, R6 with top bit set
    wr(64, 8'h10, 1'b0);
    wait_cyc(LC - 6);
    wr(65, 8'h11, 1'b0);
    wait_cyc(LC - 6);
    wr(66, 8'h92, 1'b1);
    wait_cyc(LC / 2);
    rd(0, "R3 still loading", pat(0));
    wait_cyc(LC / 2);
    rd(0, "R6 status msb", 8'h00);
    wait_cyc(SETTLE);
    rd(64, "R3 byte0", 8'h10);
    rd(65, "R3 byte1", 8'h11);
    rd(66, "R3 byte2", 8'h92);
    rd(67, "R5 rest", pat(67));

    // R11: a fresh single-byte load does not replay earlier buffer contents
    wr(96, 8'h01, 1'b0);
    wait_cyc(SETTLE);
    rd(96, "R11 new", 8'h01);
    rd(101, "R11 no replay", pat(101));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule